// File: doc/BRIEF.md
# Shared-Pool Cell Switch with Per-Output Class Queues

This block is a four-port cell switch built around one common cell store. It works in fixed time slots of N+1 clock cycles. In each slot, every input may present one 32-bit cell together with a destination port and a service class. The cells presented in a slot are captured at the slot's closing edge. During the next slot they are written into the common pool one input after another, in ascending input order. Each stored cell is then linked onto the tail of the queue that belongs to its destination and class. All queues draw on the same 64 cell slots, so one queue alone may hold the whole pool.

At the closing edge of every slot, one scheduler per output port runs. All N schedulers act at the same edge. Each one takes the head cell of its own class-0 queue. Only when that queue is empty does it take the head of its class-1 queue. The chosen cell goes out on that port's output lanes and is held there for a whole slot, and its pool slot is returned to the free map.

The block reports the occupancy of every queue so that the sender upstream can hold back traffic for queues that are filling. A cell that arrives while no pool slot is free is discarded and added to a running drop total.

Top module: `cellsw_top`

## Requirements
- R1: While reset is held, `outValid` is 0, every `qDepth` field is 0 and `dropCount` is 0.
- R2: `slotLoad` is high for exactly one cycle out of every N+1 (5) cycles. The first pulse comes in the first cycle after reset is released.
- R3: A cell captured at the rising edge where `slotLoad` is high can appear on its destination's output at the next such edge, N+1 cycles later, carrying the same 32 data bits. `outValid`, `outClass` and `outData` change only at edges where `slotLoad` is high.
- R4: All N outputs can each deliver one cell at the same slot edge, independently of each other.
- R5: At every slot edge, an output whose class-0 queue is not empty sends a class-0 cell (`outClass` = 0). It sends a class-1 cell (`outClass` = 1) only when its class-0 queue is empty.
- R6: The cells of any one queue leave in the order in which they were stored.
- R7: `qDepth` field q (bits q*7 +: 7, with q = port*2 + class) gives the number of cells held in that queue. It counts every cell written during the current slot and leaves out the cells sent at the previous slot edge.
- R8: Every queue draws on the same 64-slot pool, so one queue may reach a depth of 64. The sum of all depths never goes above 64.
- R9: A cell that finds no free pool slot is discarded: it never appears at an output, and `dropCount` goes up by one for it. A cell that finds a free slot is never discarded.
- R10: A pool slot is freed when its cell is sent, and can be used again by any queue from the next slot on.
- R11: When several inputs send to the same queue in one slot, their cells are stored, and later sent, in ascending input index order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotLoad | output | 1 | High in the last cycle of a slot; inputs are captured at the edge that ends this cycle |
| inValid | input | 4 | Per input: a cell is presented |
| inClass | input | 4 | Per input: class, 1 bit each (0 = urgent) |
| inDest | input | 8 | Per input: destination port, 2 bits each |
| inData | input | 128 | Per input: 32-bit cell payload |
| outValid | output | 4 | Per output: a cell is being delivered this slot |
| outClass | output | 4 | Per output: class of the delivered cell |
| outData | output | 128 | Per output: payload of the delivered cell |
| qDepth | output | 56 | Eight 7-bit queue occupancy counts, index port*2+class |
| dropCount | output | 16 | Number of cells discarded for lack of pool space (wraps around) |

## Verification
Every result is due at a fixed point in the slot cycle. The bench therefore does nothing but wait for the cycle in which `slotLoad` is high and sample at the falling edge of that cycle. There it applies the stimulus for the coming edge, and it checks outputs and depths that were settled by earlier edges. Output lanes for cells presented in slot k are compared two slot-load cycles later, because they are captured at one edge, stored during the following slot and sent at the edge after that. Queue depths and the drop total are compared one slot-load cycle after the stimulus, once all sequential writes have finished and before the next dequeue.

// File: rtl/cellsw_pkg.sv
package cellsw_pkg;
  localparam int NPORTS    = 4;
  localparam int NCLASS    = 2;
  localparam int POOLDEPTH = 64;
  localparam int CELLW     = 32;
  localparam int DROPW     = 16;

  localparam int PORTW  = (NPORTS > 1) ? $clog2(NPORTS) : 1;
  localparam int CLSW   = (NCLASS > 1) ? $clog2(NCLASS) : 1;
  localparam int ADDRW  = $clog2(POOLDEPTH);
  localparam int DEPTHW = $clog2(POOLDEPTH + 1);
  localparam int PHASEW = $clog2(NPORTS + 1);
  localparam int NQUEUE = NPORTS * NCLASS;
  localparam int QW     = (NQUEUE > 1) ? $clog2(NQUEUE) : 1;

  // Strobes from the control to the cell datapath
  typedef struct packed {
    logic                    capEn;    // latch the input payloads
    logic                    wrEn;     // store one payload into the pool
    logic [ADDRW-1:0]        wrAddr;
    logic [PORTW-1:0]        wrSel;    // which captured payload to store
    logic                    outLoad;  // slot edge: refresh the output lanes
    logic [NPORTS-1:0]       outHit;
    logic [NPORTS*CLSW-1:0]  outCls;
    logic [NPORTS*ADDRW-1:0] outAddr;
  } strobe_t;
endpackage

// File: rtl/cellsw_freemap.sv
module cellsw_freemap
  import cellsw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 allocTake,
  input  logic [POOLDEPTH-1:0] releaseMask,
  output logic                 allocOk,
  output logic [ADDRW-1:0]     allocAddr,
  output logic [POOLDEPTH-1:0] usedMap
);

  // Lowest-numbered free slot wins
  always_comb begin
    allocOk   = 1'b0;
    allocAddr = '0;
    for (int a = POOLDEPTH - 1; a >= 0; a--) begin
      if (!usedMap[a]) begin
        allocOk   = 1'b1;
        allocAddr = ADDRW'(a);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      usedMap <= '0;
    end else begin
      usedMap <= (usedMap & ~releaseMask) |
                 (allocTake ? (POOLDEPTH'(1) << allocAddr) : '0);
    end
  end

  // R10: only occupied slots are ever handed back
  assert_release_used_R10: assert property (@(posedge clk) disable iff (!rstN)
    (releaseMask & ~usedMap) == '0)
    else $error("freed slot was not in use");

  // R8: a granted slot is never already occupied
  assert_alloc_free_R8: assert property (@(posedge clk) disable iff (!rstN)
    allocTake |-> !usedMap[allocAddr])
    else $error("allocated an occupied slot");

endmodule

// File: rtl/cellsw_ctrl.sv
module cellsw_ctrl
  import cellsw_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NPORTS-1:0]        inValid,
  input  logic [NPORTS*CLSW-1:0]   inClass,
  input  logic [NPORTS*PORTW-1:0]  inDest,
  input  logic                     allocOk,
  input  logic [ADDRW-1:0]         allocAddr,
  output logic                     allocTake,
  output logic [POOLDEPTH-1:0]     releaseMask,
  output strobe_t                  strobe,
  output logic                     slotLoad,
  output logic [NQUEUE*DEPTHW-1:0] qDepth,
  output logic [DROPW-1:0]         dropCount
);

  logic [PHASEW-1:0] phase;
  logic              slotEnd;
  assign slotEnd = (phase == PHASEW'(NPORTS));

  // Captured headers of the cells presented at the last slot edge
  logic [NPORTS-1:0] capValid;
  logic [CLSW-1:0]   capClass [NPORTS];
  logic [PORTW-1:0]  capDest  [NPORTS];

  logic [PORTW-1:0] curIdx;
  logic             curValid;
  logic [QW-1:0]    curQ;
  assign curIdx   = PORTW'(phase);
  assign curValid = !slotEnd && capValid[curIdx];
  assign curQ     = QW'(capDest[curIdx]) * QW'(NCLASS) + QW'(capClass[curIdx]);

  // Linked queues over the shared pool
  logic [ADDRW-1:0]  head    [NQUEUE];
  logic [ADDRW-1:0]  tail    [NQUEUE];
  logic [DEPTHW-1:0] cnt     [NQUEUE];
  logic [ADDRW-1:0]  nextPtr [POOLDEPTH];

  // One scheduler per output, all evaluated in parallel
  logic [NPORTS-1:0] pickHit;
  logic [CLSW-1:0]   pickCls  [NPORTS];
  logic [QW-1:0]     pickQ    [NPORTS];
  logic [ADDRW-1:0]  pickAddr [NPORTS];

  for (genvar o = 0; o < NPORTS; o++) begin : gSched
    logic            hit;
    logic [CLSW-1:0] cls;
    always_comb begin
      hit = 1'b0;
      cls = '0;
      for (int c = NCLASS - 1; c >= 0; c--) begin
        if (cnt[o*NCLASS + c] != '0) begin
          hit = 1'b1;
          cls = CLSW'(c);
        end
      end
    end
    assign pickHit[o]  = hit;
    assign pickCls[o]  = cls;
    assign pickQ[o]    = QW'(o * NCLASS) + QW'(cls);
    assign pickAddr[o] = head[pickQ[o]];
  end

  always_comb begin
    releaseMask = '0;
    for (int o = 0; o < NPORTS; o++) begin
      if (slotEnd && pickHit[o]) releaseMask[pickAddr[o]] = 1'b1;
    end
  end

  assign allocTake = curValid && allocOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PHASEW'(NPORTS);
    end else begin
      phase <= slotEnd ? '0 : phase + PHASEW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capValid <= '0;
      for (int i = 0; i < NPORTS; i++) begin
        capClass[i] <= '0;
        capDest[i]  <= '0;
      end
    end else if (slotEnd) begin
      capValid <= inValid;
      for (int i = 0; i < NPORTS; i++) begin
        capClass[i] <= inClass[i*CLSW +: CLSW];
        capDest[i]  <= inDest[i*PORTW +: PORTW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dropCount <= '0;
    end else if (curValid && !allocOk) begin
      dropCount <= dropCount + DROPW'(1);
    end
  end

  // Enqueue happens only inside the slot, dequeue only at its edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int q = 0; q < NQUEUE; q++) begin
        head[q] <= '0;
        tail[q] <= '0;
        cnt[q]  <= '0;
      end
    end else if (allocTake) begin
      if (cnt[curQ] == '0) head[curQ] <= allocAddr;
      tail[curQ] <= allocAddr;
      cnt[curQ]  <= cnt[curQ] + DEPTHW'(1);
    end else if (slotEnd) begin
      for (int o = 0; o < NPORTS; o++) begin
        if (pickHit[o]) begin
          cnt[pickQ[o]]  <= cnt[pickQ[o]] - DEPTHW'(1);
          head[pickQ[o]] <= nextPtr[pickAddr[o]];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (allocTake && cnt[curQ] != '0) nextPtr[tail[curQ]] <= allocAddr;
  end

  always_comb begin
    strobe.capEn   = slotEnd;
    strobe.wrEn    = allocTake;
    strobe.wrAddr  = allocAddr;
    strobe.wrSel   = curIdx;
    strobe.outLoad = slotEnd;
    strobe.outHit  = pickHit;
    for (int o = 0; o < NPORTS; o++) begin
      strobe.outCls[o*CLSW +: CLSW]    = pickCls[o];
      strobe.outAddr[o*ADDRW +: ADDRW] = pickAddr[o];
    end
  end

  assign slotLoad = slotEnd;

  for (genvar q = 0; q < NQUEUE; q++) begin : gDepth
    assign qDepth[q*DEPTHW +: DEPTHW] = cnt[q];
  end

  // R2: the slot closes and a new one starts at phase zero
  assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (!rstN)
    slotEnd |=> phase == '0)
    else $error("slot phase did not wrap");

  // R8: a queue never grows beyond the pool size
  assert_enq_room_R8: assert property (@(posedge clk) disable iff (!rstN)
    allocTake |-> cnt[curQ] < DEPTHW'(POOLDEPTH))
    else $error("queue depth overflow");

  // R9: a cell that got a slot leaves the drop total untouched
  assert_no_false_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    allocTake |=> $stable(dropCount))
    else $error("drop counted for a stored cell");

endmodule

// File: rtl/cellsw_datapath.sv
module cellsw_datapath
  import cellsw_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strobe,
  input  logic [NPORTS*CELLW-1:0] inData,
  output logic [NPORTS-1:0]       outValid,
  output logic [NPORTS*CLSW-1:0]  outClass,
  output logic [NPORTS*CELLW-1:0] outData
);

  logic [CELLW-1:0] capData [NPORTS];
  logic [CELLW-1:0] pool    [POOLDEPTH];

  always_ff @(posedge clk) begin
    if (strobe.capEn) begin
      for (int i = 0; i < NPORTS; i++) capData[i] <= inData[i*CELLW +: CELLW];
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) pool[strobe.wrAddr] <= capData[strobe.wrSel];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= '0;
      outClass <= '0;
      outData  <= '0;
    end else if (strobe.outLoad) begin
      outValid <= strobe.outHit;
      outClass <= strobe.outCls;
      for (int o = 0; o < NPORTS; o++) begin
        outData[o*CELLW +: CELLW] <= pool[strobe.outAddr[o*ADDRW +: ADDRW]];
      end
    end
  end

  // R3: output lanes hold steady for the whole slot
  assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.outLoad |=> $stable(outValid) && $stable(outData) && $stable(outClass))
    else $error("output changed inside a slot");

endmodule

// File: rtl/cellsw_top.sv
module cellsw_top
  import cellsw_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  output logic                     slotLoad,
  input  logic [NPORTS-1:0]        inValid,
  input  logic [NPORTS*CLSW-1:0]   inClass,
  input  logic [NPORTS*PORTW-1:0]  inDest,
  input  logic [NPORTS*CELLW-1:0]  inData,
  output logic [NPORTS-1:0]        outValid,
  output logic [NPORTS*CLSW-1:0]   outClass,
  output logic [NPORTS*CELLW-1:0]  outData,
  output logic [NQUEUE*DEPTHW-1:0] qDepth,
  output logic [DROPW-1:0]         dropCount
);

  strobe_t              strobe;
  logic                 allocTake;
  logic                 allocOk;
  logic [ADDRW-1:0]     allocAddr;
  logic [POOLDEPTH-1:0] releaseMask;
  logic [POOLDEPTH-1:0] usedMap;

  cellsw_ctrl uCtrl (
    .clk, .rstN, .inValid, .inClass, .inDest,
    .allocOk, .allocAddr, .allocTake, .releaseMask,
    .strobe, .slotLoad, .qDepth, .dropCount
  );

  cellsw_freemap uFree (
    .clk, .rstN, .allocTake, .releaseMask, .allocOk, .allocAddr, .usedMap
  );

  cellsw_datapath uData (
    .clk, .rstN, .strobe, .inData, .outValid, .outClass, .outData
  );

  int depthSum;
  always_comb begin
    depthSum = 0;
    for (int q = 0; q < NQUEUE; q++) depthSum += int'(qDepth[q*DEPTHW +: DEPTHW]);
  end

  // R8: the free map and the queue counts agree on pool usage
  assert_pool_sum_R8: assert property (@(posedge clk) disable iff (!rstN)
    $countones(usedMap) == depthSum)
    else $error("pool usage and queue depths disagree");

  // R2: slot pulses are never back to back
  assert_slot_gap_R2: assert property (@(posedge clk) disable iff (!rstN)
    slotLoad |=> !slotLoad)
    else $error("slot pulse longer than one cycle");

  for (genvar o = 0; o < NPORTS; o++) begin : gPortChk
    // R5: a waiting urgent cell wins the slot
    assert_urgent_first_R5: assert property (@(posedge clk) disable iff (!rstN)
      slotLoad && qDepth[(o*NCLASS)*DEPTHW +: DEPTHW] != '0
      |=> outValid[o] && outClass[o*CLSW +: CLSW] == '0)
      else $error("urgent cell bypassed");
    // R4: any waiting cell on a port is served at the slot edge
    assert_port_served_R4: assert property (@(posedge clk) disable iff (!rstN)
      slotLoad && qDepth[(o*NCLASS+NCLASS-1)*DEPTHW +: DEPTHW] != '0 |=> outValid[o])
      else $error("waiting cell not served");
  end

endmodule

// File: tb/tb_cellsw_top.sv
module tb_cellsw_top;
  import cellsw_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic                     clk = 1'b0;
  logic                     rstN;
  logic                     slotLoad;
  logic [NPORTS-1:0]        inValid;
  logic [NPORTS*CLSW-1:0]   inClass;
  logic [NPORTS*PORTW-1:0]  inDest;
  logic [NPORTS*CELLW-1:0]  inData;
  logic [NPORTS-1:0]        outValid;
  logic [NPORTS*CLSW-1:0]   outClass;
  logic [NPORTS*CELLW-1:0]  outData;
  logic [NQUEUE*DEPTHW-1:0] qDepth;
  logic [DROPW-1:0]         dropCount;

  cellsw_top dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int  nCompared = 0;
  int  nMismatched = 0;
  bit  finished = 0;

  // Slot vectors: {valid[23:20], dest[19:12], class[11:8], expMask[7:4], expCls[3:0]}
  // expMask/expCls describe outputs two slot-load cycles after the row is applied.
  localparam int NROWS = 10;
  localparam logic [23:0] VEC [NROWS] = '{
    {4'hF, 8'hE4, 4'h0, 4'hF, 4'h0},  // every input to its own port
    {4'h3, 8'h0A, 4'h1, 4'h4, 4'h0},  // two inputs to port 2, mixed class
    {4'h0, 8'h00, 4'h0, 4'h4, 4'h4},  // leftover class-1 cell on port 2
    {4'hF, 8'h55, 4'h3, 4'h2, 4'h0},  // all four to port 1
    {4'h0, 8'h00, 4'h0, 4'h2, 4'h0},
    {4'h0, 8'h00, 4'h0, 4'h2, 4'h2},
    {4'h8, 8'h00, 4'h0, 4'h3, 4'h2},
    {4'h0, 8'h00, 4'h0, 4'h0, 4'h0},
    {4'h0, 8'h00, 4'h0, 4'h0, 4'h0},
    {4'h0, 8'h00, 4'h0, 4'h0, 4'h0}
  };

  // Reference model state
  logic [CELLW-1:0] mData [NQUEUE][POOLDEPTH];
  int               mHead [NQUEUE];
  int               mCnt  [NQUEUE];
  int               mUsed = 0;
  int               mDrops = 0;
  logic [NPORTS-1:0] expValid = '0;
  logic [NPORTS-1:0] expCls = '0;
  logic [CELLW-1:0]  expData [NPORTS];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nCompared++;
    if (act !== exp) begin
      nMismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [CELLW-1:0] mkData(input int row, input int idx);
    return 32'hCE00_0000 | CELLW'(row << 8) | CELLW'(idx);
  endfunction

  task automatic waitLoad();
    do @(negedge clk); while (!slotLoad);
  endtask

  task automatic checkSlot();
    for (int o = 0; o < NPORTS; o++) begin
      check("R4 outValid", 64'(outValid[o]), 64'(expValid[o]));
      if (expValid[o]) begin
        check("R5 outClass", 64'(outClass[o]), 64'(expCls[o]));
        check("R3/R6 outData", 64'(outData[o*CELLW +: CELLW]), 64'(expData[o]));
      end
    end
    for (int q = 0; q < NQUEUE; q++)
      check("R7 qDepth", 64'(qDepth[q*DEPTHW +: DEPTHW]), 64'(mCnt[q]));
    check("R9 dropCount", 64'(dropCount), 64'(mDrops));
  endtask

  // Models one slot edge: dequeue, then enqueue of the cells driven now
  task automatic stepDrive(input logic [3:0] vld, input logic [7:0] dst,
                           input logic [3:0] cls, input int row);
    for (int o = 0; o < NPORTS; o++) begin
      expValid[o] = 1'b0;
      expCls[o]   = 1'b0;
      expData[o]  = '0;
      for (int c = 0; c < NCLASS; c++) begin
        int q = o * NCLASS + c;
        if (!expValid[o] && mCnt[q] > 0) begin
          expValid[o] = 1'b1;
          expCls[o]   = c[0];
          expData[o]  = mData[q][mHead[q]];
          mHead[q]    = (mHead[q] + 1) % POOLDEPTH;
          mCnt[q]--;
          mUsed--;
        end
      end
    end
    for (int i = 0; i < NPORTS; i++) begin
      if (vld[i]) begin
        int q = int'(dst[2*i +: 2]) * NCLASS + int'(cls[i]);
        if (mUsed < POOLDEPTH) begin
          mData[q][(mHead[q] + mCnt[q]) % POOLDEPTH] = mkData(row, i);
          mCnt[q]++;
          mUsed++;
        end else begin
          mDrops++;
        end
      end
      inData[i*CELLW +: CELLW] = mkData(row, i);
    end
    inValid = vld;
    inDest  = dst;
    inClass = cls;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nMismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
      $finish;
    end
  end

  initial begin
    int maxDepth;
    int gap;
    for (int q = 0; q < NQUEUE; q++) begin
      mHead[q] = 0;
      mCnt[q]  = 0;
    end
    rstN = 1'b0;
    inValid = '0; inClass = '0; inDest = '0; inData = '0;
    repeat (3) @(negedge clk);
    check("R1 outValid", 64'(outValid), 64'(0));
    check("R1 qDepth", 64'(qDepth), 64'(0));
    check("R1 dropCount", 64'(dropCount), 64'(0));
    rstN = 1'b1;
    check("R2 first slotLoad", 64'(slotLoad), 64'(1));

    // R2: pulse spacing
    waitLoad();
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!slotLoad && gap < 20);
    check("R2 slot period", 64'(gap), 64'(NPORTS + 1));

    // Vector walk (R3, R4, R5, R6, R11)
    for (int r = 0; r < NROWS; r++) begin
      if (r != 0) waitLoad();
      if (r >= 2) begin
        check("R4 table mask", 64'(outValid), 64'(VEC[r-2][7:4]));
        check("R5/R11 table class", 64'(outClass & VEC[r-2][7:4]), 64'(VEC[r-2][3:0]));
      end
      checkSlot();
      stepDrive(VEC[r][23:20], VEC[r][19:12], VEC[r][11:8], r);
    end

    // R8/R9: flood one queue until the pool runs out
    maxDepth = 0;
    for (int k = 0; k < 24; k++) begin
      waitLoad();
      checkSlot();
      if (int'(qDepth[7*DEPTHW +: DEPTHW]) > maxDepth) maxDepth = int'(qDepth[7*DEPTHW +: DEPTHW]);
      stepDrive(4'hF, 8'hFF, 4'hF, 100 + k);
    end
    check("R8 single queue reaches pool size", 64'(maxDepth), 64'(POOLDEPTH));
    check("R9 drops occurred", 64'(dropCount != 0), 64'(1));

    // R10: drain everything, then reuse the pool
    for (int k = 0; k < 70; k++) begin
      waitLoad();
      checkSlot();
      stepDrive(4'h0, 8'h00, 4'h0, 200 + k);
    end
    check("R10 pool drained", 64'(qDepth), 64'(0));
    waitLoad();
    checkSlot();
    stepDrive(4'hF, 8'h00, 4'h0, 300);
    for (int k = 0; k < 6; k++) begin
      waitLoad();
      if (k == 0) check("R10 reuse after drain", 64'(qDepth[0 +: DEPTHW]), 64'(4));
      checkSlot();
      stepDrive(4'h0, 8'h00, 4'h0, 301 + k);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end

endmodule